// File: doc/BRIEF.md
# GPIO Interrupt Capture and Summary Bank

This block is the interrupt side of a general-purpose I/O controller. Every pin runs its own small cell. The cell passes the raw pin through a synchronizer and watches the clean sample for one of two trigger kinds: a sustained active level or a single transition. A per-pin polarity bit picks the direction. Detected events set a sticky per-pin status flag. Software reads the flag and acknowledges it by writing a one to it.

Each pin has two independent enables. The capture enable decides whether a detection may set the status flag at all. The forward enable decides only whether a set flag contributes to the single summary interrupt. A pin can therefore be masked from the summary line and still record its events. Software can also stop a level-triggered pin from recording again while its line is still active.

Configuration and status go through a plain register port: a one-cycle write strobe with an address and a data word, and a combinational read of the word at the current address. Bit i of every register belongs to pin i. The port has no handshake, so it needs no back-pressure rules.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset every status flag is 0, every configuration register and both enable registers read 0, and `irq_o` is low.
- R2: A pin whose kind bit is 0 (level) and whose capture enable is 1 sets its status flag while its synchronized line equals its polarity bit (polarity 1 = high is active, 0 = low is active). The flag is visible on a status read three clock edges after the pin changes.
- R3: A pin whose kind bit is 1 (edge) sets its status flag on a rising synchronized transition when its polarity bit is 1, and on a falling one when it is 0. A line that stays steady never sets it.
- R4: While a pin's capture enable is 0, its status flag never goes from 0 to 1, whatever its line does.
- R5: `irq_o` is a register. It is high exactly when, on the previous clock edge, at least one pin had both its status flag and its forward enable set. It therefore falls one edge after the last such flag clears.
- R6: A pin whose forward enable is 0 still captures events into status. If the forward enable is set later, a pending flag raises `irq_o`.
- R7: Writing the status address clears each flag whose data bit is 1 and leaves flags whose data bit is 0 untouched.
- R8: If a clear and a detection hit the same pin in the same cycle, the flag stays set. A level pin whose line is still active therefore reads as set straight after its acknowledge.
- R9: Changing a pin's capture enable never creates an edge detection by itself. The previous-sample register keeps tracking the line while capture is disabled.
- R10: The register addresses are 0 = kind, 1 = polarity, 2 = capture enable, 3 = forward enable, 4 = status. The first four read back the value last written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | N_PIN | Raw pin lines, asynchronous to clk |
| reg_wr | input | 1 | Write strobe, one write per cycle it is high |
| reg_addr | input | 3 | Register select (see R10) |
| reg_wdata | input | N_PIN | Write data, bit i for pin i |
| reg_rdata | output | N_PIN | Read data of the selected register, combinational |
| irq_o | output | 1 | Registered summary interrupt |

## Verification
The checker assumes that the pin lines, once past the synchronizer, change only between clock edges and are 0 during reset. It also assumes that the register address stays in the defined range whenever the write strobe is high. The bench drives pins and register writes only at falling edges. It releases reset with all pins low and writes only addresses 0 to 4. Its edge checks hold each pin level for several cycles, so every transition passes the full synchronizer before the next one arrives.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int REG_ADDR_W = 3;

  typedef enum logic [REG_ADDR_W-1:0] {
    SEL_KIND  = 3'd0,
    SEL_POL   = 3'd1,
    SEL_CAPEN = 3'd2,
    SEL_FWDEN = 3'd3,
    SEL_STAT  = 3'd4
  } reg_sel_e;

  typedef enum logic {
    TRIG_LEVEL = 1'b0,
    TRIG_EDGE  = 1'b1
  } trig_kind_e;
endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] chain [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= '0;
          else        chain[s] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= '0;
          else        chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/gpio_irq_cell.sv
module gpio_irq_cell
  import gpio_irq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic smp_i,
  input  logic kind_i,
  input  logic pol_i,
  input  logic cap_en_i,
  input  logic clr_i,
  output logic status_o
);
  logic smp_prev;
  logic lvl_hit;
  logic rise;
  logic fall;
  logic edge_hit;
  logic hit;

  // previous sample tracks the line regardless of the capture enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) smp_prev <= 1'b0;
    else        smp_prev <= smp_i;
  end

  assign rise     = smp_i & ~smp_prev;
  assign fall     = ~smp_i & smp_prev;
  assign lvl_hit  = (smp_i == pol_i);
  assign edge_hit = pol_i ? rise : fall;

  always_comb begin
    unique case (trig_kind_e'(kind_i))
      TRIG_LEVEL: hit = cap_en_i & lvl_hit;
      TRIG_EDGE:  hit = cap_en_i & edge_hit;
      default:    hit = 1'b0;
    endcase
  end

  // detection beats acknowledge in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     status_o <= 1'b0;
    else if (hit)   status_o <= 1'b1;
    else if (clr_i) status_o <= 1'b0;
  end
endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
  import gpio_irq_pkg::*;
#(
  parameter int N_PIN = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_i,
  input  logic [REG_ADDR_W-1:0] addr_i,
  input  logic [N_PIN-1:0]      wdata_i,
  output logic [N_PIN-1:0]      rdata_o,
  input  logic [N_PIN-1:0]      status_i,
  output logic [N_PIN-1:0]      kind_o,
  output logic [N_PIN-1:0]      pol_o,
  output logic [N_PIN-1:0]      cap_en_o,
  output logic [N_PIN-1:0]      fwd_en_o,
  output logic [N_PIN-1:0]      clr_o
);
  logic hit_kind;
  logic hit_pol;
  logic hit_cap;
  logic hit_fwd;
  logic hit_stat;

  assign hit_kind = wr_i && (addr_i == SEL_KIND);
  assign hit_pol  = wr_i && (addr_i == SEL_POL);
  assign hit_cap  = wr_i && (addr_i == SEL_CAPEN);
  assign hit_fwd  = wr_i && (addr_i == SEL_FWDEN);
  assign hit_stat = wr_i && (addr_i == SEL_STAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_o   <= '0;
      pol_o    <= '0;
      cap_en_o <= '0;
      fwd_en_o <= '0;
    end else begin
      if (hit_kind) kind_o   <= wdata_i;
      if (hit_pol)  pol_o    <= wdata_i;
      if (hit_cap)  cap_en_o <= wdata_i;
      if (hit_fwd)  fwd_en_o <= wdata_i;
    end
  end

  assign clr_o = hit_stat ? wdata_i : '0;

  always_comb begin
    case (addr_i)
      SEL_KIND:  rdata_o = kind_o;
      SEL_POL:   rdata_o = pol_o;
      SEL_CAPEN: rdata_o = cap_en_o;
      SEL_FWDEN: rdata_o = fwd_en_o;
      SEL_STAT:  rdata_o = status_i;
      default:   rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/gpio_irq_summary.sv
module gpio_irq_summary #(
  parameter int N_PIN = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_PIN-1:0] status_i,
  input  logic [N_PIN-1:0] fwd_en_i,
  output logic             irq_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_o <= 1'b0;
    else        irq_o <= |(status_i & fwd_en_i);
  end
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_irq_pkg::*;
#(
  parameter int N_PIN       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [N_PIN-1:0]      pin_i,
  input  logic                  reg_wr,
  input  logic [REG_ADDR_W-1:0] reg_addr,
  input  logic [N_PIN-1:0]      reg_wdata,
  output logic [N_PIN-1:0]      reg_rdata,
  output logic                  irq_o
);
  logic [N_PIN-1:0] smp_cur;
  logic [N_PIN-1:0] kind;
  logic [N_PIN-1:0] pol;
  logic [N_PIN-1:0] cap_en;
  logic [N_PIN-1:0] fwd_en;
  logic [N_PIN-1:0] clr_mask;
  logic [N_PIN-1:0] status;

  gpio_irq_sync #(.WIDTH(N_PIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst_n (rst_n),
    .d_i (pin_i),
    .q_o (smp_cur)
  );

  gpio_irq_regs #(.N_PIN(N_PIN)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_i     (reg_wr),
    .addr_i   (reg_addr),
    .wdata_i  (reg_wdata),
    .rdata_o  (reg_rdata),
    .status_i (status),
    .kind_o   (kind),
    .pol_o    (pol),
    .cap_en_o (cap_en),
    .fwd_en_o (fwd_en),
    .clr_o    (clr_mask)
  );

  genvar p;
  generate
    for (p = 0; p < N_PIN; p++) begin : g_pin
      gpio_irq_cell u_cell (
        .clk      (clk),
        .rst_n    (rst_n),
        .smp_i    (smp_cur[p]),
        .kind_i   (kind[p]),
        .pol_i    (pol[p]),
        .cap_en_i (cap_en[p]),
        .clr_i    (clr_mask[p]),
        .status_o (status[p])
      );
    end
  endgenerate

  gpio_irq_summary #(.N_PIN(N_PIN)) u_sum (
    .clk      (clk),
    .rst_n    (rst_n),
    .status_i (status),
    .fwd_en_i (fwd_en),
    .irq_o    (irq_o)
  );
endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk #(
  parameter int N_PIN = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_PIN-1:0] smp_cur,
  input logic [N_PIN-1:0] kind,
  input logic [N_PIN-1:0] pol,
  input logic [N_PIN-1:0] cap_en,
  input logic [N_PIN-1:0] fwd_en,
  input logic [N_PIN-1:0] clr_mask,
  input logic [N_PIN-1:0] status,
  input logic             irq_o
);
  // R1: held in reset, nothing pending and summary low
  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_clear_R1: assert (status == '0 && !irq_o && cap_en == '0 && fwd_en == '0)
        else $error("R1 reset state violated");
    end
  end

  // R4: no new flag on a pin whose capture was off
  assert_no_capture_when_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (status & ~$past(status) & ~$past(cap_en)) == '0);

  // R3: an edge pin whose sampled line did not move cannot gain a flag
  assert_edge_needs_transition_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (status & ~$past(status) & $past(kind) & ~($past(smp_cur) ^ $past(smp_cur, 2))) == '0);

  // R2 / R8: an enabled level pin at its active level is set on the next cycle
  assert_level_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cap_en & ~kind & ~(smp_cur ^ pol)) & ~status) == '0);

  // R7: an acknowledged pin with capture off is clear afterwards
  assert_ack_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(clr_mask & ~cap_en) & status) == '0);

  // R5: summary follows enabled pending flags one edge later
  assert_summary_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(|(status & fwd_en)));
  assert_summary_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_o |-> !$past(|(status & fwd_en)));
endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.N_PIN(N_PIN)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .smp_cur  (smp_cur),
  .kind     (kind),
  .pol      (pol),
  .cap_en   (cap_en),
  .fwd_en   (fwd_en),
  .clr_mask (clr_mask),
  .status   (status),
  .irq_o    (irq_o)
);

// File: tb/gpio_irq_bank_bench.sv
`timescale 1ns/1ps
module gpio_irq_bank_bench;
  localparam int N = 8;
  localparam logic [2:0] A_KIND = 3'd0, A_POL = 3'd1, A_CAP = 3'd2, A_FWD = 3'd3, A_STAT = 3'd4;

  typedef struct packed {
    logic [7:0] kind;
    logic [7:0] pol;
    logic [7:0] p0;
    logic [7:0] p1;
    logic [7:0] exp;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{kind: 8'h00, pol: 8'hFF, p0: 8'h00, p1: 8'h0F, exp: 8'h0F},
    '{kind: 8'h00, pol: 8'h00, p0: 8'hFF, p1: 8'hF0, exp: 8'h0F},
    '{kind: 8'hFF, pol: 8'hFF, p0: 8'h00, p1: 8'hA5, exp: 8'hA5},
    '{kind: 8'hFF, pol: 8'h00, p0: 8'hFF, p1: 8'h3C, exp: 8'hC3},
    '{kind: 8'hFF, pol: 8'hFF, p0: 8'hFF, p1: 8'hFF, exp: 8'h00},
    '{kind: 8'hF0, pol: 8'hCC, p0: 8'h00, p1: 8'hFF, exp: 8'hCF},
    '{kind: 8'h0F, pol: 8'h55, p0: 8'hAA, p1: 8'h55, exp: 8'hFF}
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] pin_i = '0;
  logic         reg_wr = 1'b0;
  logic [2:0]   reg_addr = '0;
  logic [N-1:0] reg_wdata = '0;
  logic [N-1:0] reg_rdata;
  logic         irq_o;

  int checks = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  gpio_irq_bank #(.N_PIN(N)) u_gpio_irq_bank (
    .clk (clk), .rst_n (rst_n), .pin_i (pin_i), .reg_wr (reg_wr),
    .reg_addr (reg_addr), .reg_wdata (reg_wdata), .reg_rdata (reg_rdata), .irq_o (irq_o)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    reg_addr = a;
    #0.5;
    d = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [7:0] v;
    idle(3);
    // R1: state held during and just after reset
    check("R1 irq during reset", {7'd0, irq_o}, 8'h00);
    rst_n = 1'b1;
    idle(1);
    for (int a = 0; a < 5; a++) begin
      rd(a[2:0], v);
      check("R1 register reset", v, 8'h00);
    end
    check("R1 irq after reset", {7'd0, irq_o}, 8'h00);

    // table walk: R2/R3 capture, R6 masked capture then forwarding
    for (int i = 0; i < NV; i++) begin
      wr(A_CAP, 8'h00);
      wr(A_FWD, 8'h00);
      wr(A_KIND, VECS[i].kind);
      wr(A_POL, VECS[i].pol);
      pin_i = VECS[i].p0;
      idle(4);
      wr(A_STAT, 8'hFF);
      wr(A_CAP, 8'hFF);
      idle(4);
      pin_i = VECS[i].p1;
      idle(4);
      rd(A_STAT, v);
      check("R2/R3 table status", v, VECS[i].exp);
      check("R6 masked irq low", {7'd0, irq_o}, 8'h00);
      wr(A_FWD, 8'hFF);
      idle(1);
      check("R6 forward after enable", {7'd0, irq_o}, {7'd0, (VECS[i].exp != 8'h00)});
    end

    // R10: configuration readback
    wr(A_CAP, 8'h00);
    wr(A_KIND, 8'h3C); wr(A_POL, 8'h96); wr(A_FWD, 8'h5A);
    rd(A_KIND, v); check("R10 kind readback", v, 8'h3C);
    rd(A_POL, v);  check("R10 pol readback", v, 8'h96);
    rd(A_FWD, v);  check("R10 fwd readback", v, 8'h5A);
    rd(A_CAP, v);  check("R10 cap readback", v, 8'h00);

    // R4: capture off, lines active and toggling
    wr(A_FWD, 8'h00);
    wr(A_KIND, 8'h0F); wr(A_POL, 8'hFF);
    wr(A_STAT, 8'hFF);
    for (int k = 0; k < 4; k++) begin
      pin_i = (k % 2 == 0) ? 8'hFF : 8'h00;
      idle(4);
    end
    pin_i = 8'hFF; idle(4);
    rd(A_STAT, v); check("R4 no capture when off", v, 8'h00);

    // R9: toggling capture enable on steady-high edge pins
    wr(A_KIND, 8'hFF); wr(A_POL, 8'hFF);
    pin_i = 8'hFF; idle(4);
    wr(A_STAT, 8'hFF);
    for (int k = 0; k < 3; k++) begin
      wr(A_CAP, 8'hFF);
      wr(A_CAP, 8'h00);
    end
    wr(A_CAP, 8'hFF);
    idle(4);
    rd(A_STAT, v); check("R9 enable toggle makes no edge", v, 8'h00);

    // R7: selective write-one-to-clear
    pin_i = 8'h00; idle(4);
    wr(A_STAT, 8'hFF);
    pin_i = 8'hA5; idle(4);
    rd(A_STAT, v); check("R7 captured before ack", v, 8'hA5);
    wr(A_STAT, 8'h05);
    rd(A_STAT, v); check("R7 partial clear", v, 8'hA0);
    wr(A_STAT, 8'h00);
    rd(A_STAT, v); check("R7 zero write no effect", v, 8'hA0);

    // R8: level pin still active keeps its flag across an ack
    wr(A_CAP, 8'h00); wr(A_STAT, 8'hFF);
    pin_i = 8'h01; wr(A_KIND, 8'h00); wr(A_POL, 8'h01);
    wr(A_CAP, 8'h01);
    idle(4);
    rd(A_STAT, v); check("R2 level captured", v, 8'h01);
    wr(A_STAT, 8'h01);
    rd(A_STAT, v); check("R8 detect beats clear", v, 8'h01);
    pin_i = 8'h00; idle(4);
    wr(A_STAT, 8'h01);
    rd(A_STAT, v); check("R8 clear after line idle", v, 8'h00);

    // R5: summary falls one edge after the flag clears
    wr(A_CAP, 8'h00);
    wr(A_KIND, 8'hFF); wr(A_POL, 8'hFF);
    wr(A_STAT, 8'hFF);
    wr(A_CAP, 8'hFF);
    pin_i = 8'h10; idle(4);
    wr(A_FWD, 8'h10);
    idle(1);
    check("R5 irq raised", {7'd0, irq_o}, 8'h01);
    wr(A_STAT, 8'h10);
    rd(A_STAT, v); check("R5 flag cleared", v, 8'h00);
    check("R5 irq still high one edge", {7'd0, irq_o}, 8'h01);
    idle(1);
    check("R5 irq dropped", {7'd0, irq_o}, 8'h00);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end
endmodule